// File: doc/BRIEF.md
# Multiplexed Asynchronous External Memory Port

This block connects an internal 32-bit word stream to asynchronous external memory through sixteen pins. The same pins carry the address and then the data. One command starts a transfer. The command gives a direction, a start address, a word count, a bus mode and a strobe width.

The block has two bus modes:
- **Byte mode:** the address is 24 bits wide and data moves one byte per strobe.
- **Halfword mode:** the address is 16 bits wide and data moves sixteen bits per strobe.

On a read, the narrow transfers are gathered into 32-bit words. On a write, each 32-bit word is split back into narrow transfers.

The external side is assumed to hold a latched address that counts up by one after every strobe. For that reason, the address is only sent at the start of a transfer and whenever the next location opens a new 256-location page. On the internal side, a request/acknowledge pair moves one word at a time.

Top module: `xmem_mux_port`

## Requirements
- R1: While reset is held and after its release, `ale` and `xfer_req` are 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, and `busy` and `done` are 0.
- R2: In byte mode (`byte_mode`=1), an address phase is two consecutive `ale` cycles. The first cycle drives address bits 23:16 on `ad_out[7:0]` with `ad_out[15:8]`=0. The second cycle drives address bits 15:0. Data moves on `ad_out[7:0]`/`ad_in[7:0]`.
- R3: In halfword mode (`byte_mode`=0), an address phase is one `ale` cycle driving address bits 15:0. Data moves on all 16 pins.
- R4: A read packs transfers little-endian. The first transfer of a word lands in bits 7:0 (byte mode) or 15:0 (halfword mode).
- R5: A write unpacks each word in the same little-endian order, driving the data with `ad_oe`=1 while `wr_n` is low. `ad_oe` is 0 whenever `rd_n` is low.
- R6: Each strobe stays low for `strobe_len` cycles, with values below 2 treated as 2. Only one strobe is low at a time. Each strobe is followed by at least one cycle with both strobes high.
- R7: The external address goes up by one per transfer. An address phase occurs only at the start of a transfer and before a transfer whose address has bits 7:0 equal to zero.
- R8: A write raises `xfer_req` and takes `wr_word` on `xfer_ack` before the word's transfers begin. A read raises `xfer_req` with `rd_word` valid after the word's last transfer and holds it until `xfer_ack`.
- R9: `busy` is 1 from the cycle after `start` until the last strobe of the transfer has finished. `done` is 1 for exactly one cycle, in the cycle where `busy` falls, and `busy` is 0 whenever `done` is 1.
- R10: A `start` with `word_count`=0 produces a single `done` cycle with no address phase, no strobe and no `busy`.
- R11: A `start` while `busy` is 1 is ignored, and the running transfer finishes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command pulse, accepted only when idle |
| rd_mode | input | 1 | 1 = read from external memory, 0 = write |
| byte_mode | input | 1 | 1 = 24-bit address with byte data, 0 = 16-bit address with halfword data |
| start_addr | input | 24 | External address of the first transfer |
| word_count | input | 8 | Number of 32-bit words to move |
| strobe_len | input | 5 | Strobe low time in cycles (minimum 2) |
| wr_word | input | 32 | Write word, taken when `xfer_req` and `xfer_ack` are both high |
| xfer_ack | input | 1 | Internal side accepts or supplies a word |
| xfer_req | output | 1 | Word wanted (write) or word ready (read) |
| rd_word | output | 32 | Packed read word, valid while `xfer_req` is high in a read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ad_out | output | 16 | Address/data driven onto the shared pins |
| ad_in | input | 16 | Data read from the shared pins |

## Verification
Every output comes straight from the registered state. A new command therefore shows as `busy` one clock edge after `start`. The bench drives inputs and samples outputs on falling edges, so each check falls half a cycle after the edge that caused it.

The external memory model works on those samples:
- It records the address on `ale` cycles.
- It measures each strobe's low time in samples and compares it with the clamped width.
- It advances its own address when a strobe rises.

Read data is checked once the word is handed over on `xfer_req`. Written data is compared after `done`, counting `ale` cycles, strobes and `done` pulses over the whole transfer. The `done` and `busy` relation is checked on the very sample where `done` appears.

// File: rtl/xmem_mux_port.sv
module xmem_mux_port #(
  parameter int CW = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_mode,
  input  logic          byte_mode,
  input  logic [23:0]   start_addr,
  input  logic [CW-1:0] word_count,
  input  logic [SW-1:0] strobe_len,
  input  logic [31:0]   wr_word,
  input  logic          xfer_ack,
  output logic          xfer_req,
  output logic [31:0]   rd_word,
  output logic          busy,
  output logic          done,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ad_oe,
  output logic [15:0]   ad_out,
  input  logic [15:0]   ad_in
);
  localparam logic [SW-1:0] MIN_STROBE = SW'(2);

  typedef enum logic [2:0] {S_IDLE, S_WREQ, S_AHI, S_ALO, S_STRB, S_GAP, S_DLV} st_t;

  st_t           st;
  logic [23:0]   addr;
  logic [CW-1:0] left;
  logic [1:0]    part;
  logic [SW-1:0] tmr, nstr;
  logic          bmode, rmode, need_a, done_r;
  logic [31:0]   sh;

  wire  last_part = bmode ? (part == 2'd3) : (part == 2'd1);
  wire  [23:0] addr_nx = addr + 24'd1;
  st_t  a_st;
  assign a_st = bmode ? S_AHI : S_ALO;

  assign ale      = (st == S_AHI) || (st == S_ALO);
  assign ad_oe    = ale || (st == S_STRB && !rmode);
  assign rd_n     = !(st == S_STRB && rmode);
  assign wr_n     = !(st == S_STRB && !rmode);
  assign xfer_req = (st == S_WREQ) || (st == S_DLV);
  assign busy     = (st != S_IDLE);
  assign done     = done_r;
  assign rd_word  = sh;
  assign ad_out   = (st == S_AHI) ? {8'h00, addr[23:16]} :
                    (st == S_ALO) ? addr[15:0] :
                    bmode         ? {8'h00, sh[7:0]} : sh[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; left <= '0; part <= '0; tmr <= '0; nstr <= MIN_STROBE;
      bmode <= 1'b0; rmode <= 1'b0; need_a <= 1'b0; done_r <= 1'b0; sh <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (word_count == '0) done_r <= 1'b1;
          else begin
            addr   <= byte_mode ? start_addr : {8'h00, start_addr[15:0]};
            left   <= word_count;
            bmode  <= byte_mode;
            rmode  <= rd_mode;
            nstr   <= (strobe_len < MIN_STROBE) ? MIN_STROBE : strobe_len;
            need_a <= 1'b1;
            part   <= '0;
            st     <= rd_mode ? (byte_mode ? S_AHI : S_ALO) : S_WREQ;
          end
        end
        S_WREQ: if (xfer_ack) begin
          sh   <= wr_word;
          part <= '0;
          tmr  <= '0;
          st   <= need_a ? a_st : S_STRB;
        end
        S_AHI: st <= S_ALO;
        S_ALO: begin
          need_a <= 1'b0;
          tmr    <= '0;
          st     <= S_STRB;
        end
        S_STRB: if (tmr == nstr - SW'(1)) begin
          addr <= addr_nx;
          if (addr_nx[7:0] == 8'h00) need_a <= 1'b1;
          if (rmode) sh <= bmode ? {ad_in[7:0], sh[31:8]} : {ad_in, sh[31:16]};
          else       sh <= bmode ? (sh >> 8) : (sh >> 16);
          st <= S_GAP;
        end else tmr <= tmr + SW'(1);
        S_GAP: begin
          tmr <= '0;
          if (!last_part) begin
            part <= part + 2'd1;
            st   <= need_a ? a_st : S_STRB;
          end else if (rmode) st <= S_DLV;
          else begin
            left <= left - CW'(1);
            if (left == CW'(1)) begin st <= S_IDLE; done_r <= 1'b1; end
            else st <= S_WREQ;
          end
        end
        S_DLV: if (xfer_ack) begin
          part <= '0;
          tmr  <= '0;
          left <= left - CW'(1);
          if (left == CW'(1)) begin st <= S_IDLE; done_r <= 1'b1; end
          else st <= need_a ? a_st : S_STRB;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module xmem_mux_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic        ad_oe,
  input logic [15:0] ad_out,
  input logic        busy,
  input logic        done,
  input logic        xfer_req
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)));
  p_rd_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_n) |=> !rd_n);
  p_wr_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_n) |=> !wr_n);
  p_bus_released_r5: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);
  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && $past(!wr_n)) |-> $stable(ad_out));
  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n) ale |-> ad_oe);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |-> busy);
endmodule

bind xmem_mux_port xmem_mux_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .ad_out(ad_out), .busy(busy), .done(done), .xfer_req(xfer_req)
);

// File: tb/xmem_mux_port_tb_top.sv
`timescale 1ns/1ps
module xmem_mux_port_tb_top;
  typedef struct packed {
    logic        wide;
    logic        rd;
    logic [23:0] addr;
    logic [7:0]  cnt;
    logic [4:0]  sw;
    logic [7:0]  ale;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 24'h123400, 8'd2, 5'd3,  8'd2},
    '{1'b0, 1'b1, 24'h0000FE, 8'd2, 5'd2,  8'd2},
    '{1'b1, 1'b0, 24'hABCDFC, 8'd3, 5'd5,  8'd4},
    '{1'b0, 1'b0, 24'h004010, 8'd2, 5'd31, 8'd1},
    '{1'b1, 1'b1, 24'h0001FF, 8'd1, 5'd0,  8'd4},
    '{1'b0, 1'b0, 24'h0000FF, 8'd1, 5'd1,  8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rd_mode = 0, byte_mode = 0, xfer_ack = 0;
  logic [23:0] start_addr = '0;
  logic [7:0]  word_count = '0;
  logic [4:0]  strobe_len = '0;
  logic [31:0] wr_word = '0;
  logic xfer_req, busy, done, ale, rd_n, wr_n, ad_oe;
  logic [31:0] rd_word;
  logic [15:0] ad_out, ad_in;

  always #4 clk = ~clk;

  xmem_mux_port dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .byte_mode(byte_mode),
    .start_addr(start_addr), .word_count(word_count), .strobe_len(strobe_len),
    .wr_word(wr_word), .xfer_ack(xfer_ack), .xfer_req(xfer_req), .rd_word(rd_word),
    .busy(busy), .done(done), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
    .ad_out(ad_out), .ad_in(ad_in)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rf(input logic [23:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {8'h00, a[23:16]};
  endfunction

  function automatic logic [31:0] gen(input int i);
    return 32'h1357_9BDF ^ (32'(i) * 32'h0102_0408);
  endfunction

  // external memory model
  logic [23:0] maddr = '0;
  logic [15:0] wmem [int];
  logic [31:0] got [8];
  logic cur_wide = 0, cur_rd = 0;
  int   expw = 2, ale_cnt = 0, strb_cnt = 0, width_err = 0, hi_err = 0, oe_err = 0, done_cnt = 0, busy_err = 0, widx = 0, run = 0;
  logic prev_ale = 0, prev_low = 0, prev_wr = 0;
  logic [15:0] wlast = '0;

  assign ad_in = (!rd_n) ? rf(maddr) : 16'h0000;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) begin
        ale_cnt++;
        if (!prev_ale) begin
          if (cur_wide) begin
            if (ad_out[15:8] != 8'h00) hi_err++;
            maddr[23:16] = ad_out[7:0];
          end else maddr = {8'h00, ad_out};
        end else maddr[15:0] = ad_out;
      end
      if (!rd_n || !wr_n) begin
        run++;
        if (!wr_n) begin wlast = ad_out; if (!ad_oe) oe_err++; end
        if (!rd_n && ad_oe) oe_err++;
      end else if (prev_low) begin
        strb_cnt++;
        if (run != expw) width_err++;
        run = 0;
        if (prev_wr) wmem[int'(maddr)] = wlast;
        maddr = maddr + 24'd1;
      end
      if (xfer_req) begin
        if (cur_rd) begin if (widx < 8) got[widx] = rd_word; end
        else wr_word = gen(widx);
        widx++;
        xfer_ack = 1'b1;
      end else xfer_ack = 1'b0;
      if (done) begin done_cnt++; if (busy) busy_err++; end
      prev_ale = ale; prev_low = !rd_n || !wr_n; prev_wr = !wr_n;
    end
  end

  task automatic run_vec(input vec_t v, input bit poke, input string tag);
    int parts, t;
    logic [31:0] e;
    logic [23:0] a;
    parts = v.wide ? 4 : 2;
    cur_wide = v.wide; cur_rd = v.rd; expw = (v.sw < 2) ? 2 : int'(v.sw);
    ale_cnt = 0; strb_cnt = 0; width_err = 0; hi_err = 0; oe_err = 0; done_cnt = 0; busy_err = 0; widx = 0;
    wmem.delete();
    byte_mode = v.wide; rd_mode = v.rd; start_addr = v.addr; word_count = v.cnt; strobe_len = v.sw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      byte_mode = ~v.wide; rd_mode = ~v.rd; start_addr = 24'h00_00F0; word_count = 8'd7; strobe_len = 5'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, {tag, " watchdog"}, t, 0);
    repeat (3) @(negedge clk);
    chk(ale_cnt == int'(v.ale), {tag, v.wide ? " R2 R7 ale cycles" : " R3 R7 ale cycles"}, ale_cnt, v.ale);
    chk(strb_cnt == int'(v.cnt) * parts, {tag, " R7 strobe count"}, strb_cnt, int'(v.cnt) * parts);
    chk(width_err == 0, {tag, " R6 strobe width"}, width_err, 0);
    chk(hi_err == 0, {tag, " R2 upper address pins"}, hi_err, 0);
    chk(oe_err == 0, {tag, " R5 bus drive"}, oe_err, 0);
    chk(done_cnt == 1 && busy_err == 0, {tag, " R9 done pulse"}, done_cnt, 1);
    chk(widx == int'(v.cnt), {tag, " R8 handshakes"}, widx, v.cnt);
    for (int i = 0; i < int'(v.cnt); i++) begin
      if (v.rd) begin
        e = '0;
        for (int j = 0; j < parts; j++) begin
          a = v.addr + 24'(i * parts + j);
          if (v.wide) e[8*j +: 8] = rf(a)[7:0];
          else        e[16*j +: 16] = rf(a);
        end
        chk(got[i] == e, {tag, " R4 read packing"}, got[i], e);
      end else begin
        for (int j = 0; j < parts; j++) begin
          a = v.addr + 24'(i * parts + j);
          e = v.wide ? {24'h0, gen(i)[8*j +: 8]} : {16'h0, gen(i)[16*j +: 16]};
          chk(wmem.exists(int'(a)) && wmem[int'(a)] == e[15:0], {tag, " R5 write unpacking"},
              wmem.exists(int'(a)) ? longint'(wmem[int'(a)]) : -1, e);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && !ad_oe && !busy && !done && !xfer_req, "R1 state in reset",
        {ale, rd_n, wr_n, ad_oe, busy, done, xfer_req}, 7'b0110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !ad_oe && !busy && !done && !xfer_req, "R1 state after reset",
        {ale, rd_n, wr_n, ad_oe, busy, done, xfer_req}, 7'b0110000);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0, $sformatf("vec%0d", k));

    // R10: zero word count
    ale_cnt = 0; strb_cnt = 0; done_cnt = 0; busy_err = 0;
    byte_mode = 1; rd_mode = 1; start_addr = 24'h000010; word_count = 0; strobe_len = 4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy, "R10 immediate done", {done, busy}, 2'b10);
    repeat (6) @(negedge clk);
    chk(ale_cnt == 0 && strb_cnt == 0 && done_cnt == 1, "R10 no bus activity", ale_cnt + strb_cnt, 0);

    // R11: start while busy is ignored
    run_vec(VECS[0], 1'b1, "R11 restart ignored");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule